// File: doc/BRIEF.md
# Nine-Bit Serial Register Bridge

This block is the host-facing serial slave of a display bridge. A host talks to it over a three-wire serial link (clock, chip select, data in) plus a data-out line. Each transfer is a nine-bit frame. The leading bit marks the frame as a command or as data, and the remaining eight bits carry one byte. Command frames pick a register address. Data frames either fill a 16-bit register, sent as two bytes with the low byte first, or feed payload bytes for an outgoing display packet into a small byte queue. The queue drains through a valid/ready stream toward the packet engine.

A register is read back through a fixed sequence. First a three-frame arming step, then a command frame naming the target, then a command frame carrying the read key. After that, the next sixteen serial clocks shift the value out on the data-out line. A dedicated 16-bit write to the operation control register returns every register to its default value. Five bits of the configuration register drive mode pins toward the rest of the bridge.

The serial pins are sampled with the block's own clock through two-flop synchronisers. The serial clock must therefore run well below the system clock: each high and each low phase must last at least four system clocks.

Top module: `spi9_cfg_bridge`

## Requirements
- R1: A frame is nine bits taken on rising serial-clock edges while chip select is low. Bit 1 is the flag (0 = command, 1 = data) and bits 2 to 9 are the byte, most significant bit first. Raising chip select before the ninth bit discards the partial frame.
- R2: A command frame with a register address, followed by two data frames (low byte, then high byte), writes that 16-bit register. Each further pair of data frames writes the same address again.
- R3: The register window runs from 0xB0 to 0xEB. Address 0xB0 always reads the device identifier (default 0x5A31) and cannot be written. Data frames aimed at a read-only or out-of-window address change nothing. A read-back of an out-of-window address returns zero.
- R4: Every command frame restarts the byte phase at the low byte, so a low byte left without its partner is dropped.
- R5: A command frame of 0xBF opens a payload stream whose budget is the value held at 0xBC. Each following data frame is pushed into the byte queue until the budget is used up, and later data frames are discarded. `pay_left` shows the remaining budget.
- R6: Any command frame closes an open payload stream and sets `pay_left` to zero. The data frames that follow go to the newly selected register.
- R7: The payload output is valid/ready. A byte stays on `pay_data` with `pay_valid` high until `pay_ready` accepts it. A payload byte that arrives while the queue (depth `FIFO_DEPTH`) is full is dropped, but it still consumes budget.
- R8: A read-back is armed by command 0xD4, then data 0xFA, then data 0x00. It continues with a command frame naming the target and then command 0xFA. The next 16 rising serial edges shift the value out on `spi_miso`, most significant bit first; the first bit is present before the first edge. Any other order arms nothing, and `spi_miso` stays low. The arming data frames are also an ordinary write of 0x00FA to 0xD4.
- R9: Writing 0x0100 to 0xC0 resets every register to its default. Any other value written to 0xC0 is stored like a normal register value.
- R10: The configuration register at 0xB7 drives the mode pins: bit 0 drives `cfg_hs_mode`, bit 3 drives `cfg_video_en`, bit 6 drives `cfg_dcs_pkt`, bit 8 drives `cfg_ecc_en` and bit 9 drives `cfg_eot_en`.
- R11: After reset, `pay_valid`, `pay_left`, `spi_miso` and all five mode pins are low, and every register other than the identifier reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, mode 0 |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read-back data toward the host |
| pay_valid | output | 1 | Payload byte available |
| pay_ready | input | 1 | Packet path accepts the payload byte |
| pay_data | output | 8 | Payload byte |
| pay_left | output | 16 | Remaining payload budget of the open stream |
| cfg_hs_mode | output | 1 | High-speed mode select |
| cfg_video_en | output | 1 | Video stream enable |
| cfg_dcs_pkt | output | 1 | Command-set packets (1) versus generic packets (0) |
| cfg_ecc_en | output | 1 | Packet error check and CRC enable |
| cfg_eot_en | output | 1 | End-of-transmission packet enable |

## Verification
The bench builds the block with its default parameters: the full 0xB0 to 0xEB window (60 registers) and a four-entry payload queue. The window is small enough that every address gets a distinct pattern written and then read back through the serial read-back path, with expected values worked out from the address alone. The shallow queue puts overflow within reach of a six-byte packet while the sink is held off, so dropping and holding are both exercised.

// File: rtl/spi9_bridge_pkg.sv
package spi9_bridge_pkg;

  localparam int FRM_BITS = 9;
  localparam int FRM_CW   = $clog2(FRM_BITS);

  typedef struct packed {
    logic       is_data;
    logic [7:0] val;
  } frame_t;

  localparam logic [7:0]  ADR_CFG       = 8'hB7;
  localparam logic [7:0]  ADR_PKT_LEN   = 8'hBC;
  localparam logic [7:0]  ADR_STREAM    = 8'hBF;
  localparam logic [7:0]  ADR_OPCTL     = 8'hC0;
  localparam logic [7:0]  ADR_RD_ARM    = 8'hD4;
  localparam logic [7:0]  RD_KEY        = 8'hFA;
  localparam logic [7:0]  RD_ZERO       = 8'h00;
  localparam logic [15:0] SOFT_RST_WORD = 16'h0100;

  localparam int CFG_HS_BIT  = 0;
  localparam int CFG_VID_BIT = 3;
  localparam int CFG_DCS_BIT = 6;
  localparam int CFG_ECC_BIT = 8;
  localparam int CFG_EOT_BIT = 9;

  typedef enum logic [2:0] {
    ARM_IDLE,
    ARM_CMD,
    ARM_KEY,
    ARM_READY,
    ARM_TARGET
  } arm_t;

endpackage

// File: rtl/spi9_frame_link.sv
module spi9_frame_link
  import spi9_bridge_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck_i,
  input  logic                 csn_i,
  input  logic                 mosi_i,
  input  logic                 tx_load_i,
  input  logic [WORD_BITS-1:0] tx_word_i,
  output logic                 miso_o,
  output logic                 tx_busy_o,
  output logic                 frm_valid_o,
  output frame_t               frm_o,
  output logic [FRM_CW-1:0]    bit_cnt_o
);

  localparam int                TXW      = $clog2(WORD_BITS);
  localparam logic [FRM_CW-1:0] LAST_BIT = FRM_CW'(FRM_BITS - 1);
  localparam logic [TXW-1:0]    TX_LAST  = TXW'(WORD_BITS - 1);

  logic [2:0] sck_q;
  logic [1:0] csn_q;
  logic [1:0] mosi_q;
  logic       csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
      csn_d  <= 1'b1;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      csn_q  <= {csn_q[0], csn_i};
      mosi_q <= {mosi_q[0], mosi_i};
      csn_d  <= csn_q[1];
    end
  end

  logic sck_rise, csn_s, csn_up, sd;
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign csn_s    = csn_q[1];
  assign csn_up   = csn_s & ~csn_d;
  assign sd       = mosi_q[1];

  logic [FRM_BITS-2:0] sr;
  logic [FRM_CW-1:0]   cnt;
  logic                tx_pend;

  // frame deserialiser, idle while a read-back word is pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      sr          <= '0;
      frm_valid_o <= 1'b0;
      frm_o       <= '0;
    end else begin
      frm_valid_o <= 1'b0;
      if (csn_s) begin
        cnt <= '0;
      end else if (sck_rise && !tx_pend) begin
        if (cnt == LAST_BIT) begin
          cnt         <= '0;
          frm_valid_o <= 1'b1;
          frm_o       <= frame_t'({sr, sd});
        end else begin
          cnt <= cnt + 1'b1;
          sr  <= {sr[FRM_BITS-3:0], sd};
        end
      end
    end
  end

  logic [WORD_BITS-1:0] tx_sr;
  logic [TXW-1:0]       tx_cnt;

  // read-back shifter: survives chip-select gaps until shifting starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      tx_cnt  <= '0;
      tx_pend <= 1'b0;
    end else if (tx_load_i) begin
      tx_sr   <= tx_word_i;
      tx_cnt  <= '0;
      tx_pend <= 1'b1;
    end else if (tx_pend) begin
      if (csn_up && tx_cnt != '0) begin
        tx_pend <= 1'b0;
        tx_cnt  <= '0;
      end else if (!csn_s && sck_rise) begin
        tx_sr <= {tx_sr[WORD_BITS-2:0], 1'b0};
        if (tx_cnt == TX_LAST) begin
          tx_pend <= 1'b0;
          tx_cnt  <= '0;
        end else begin
          tx_cnt <= tx_cnt + 1'b1;
        end
      end
    end
  end

  assign miso_o    = tx_pend & tx_sr[WORD_BITS-1];
  assign tx_busy_o = tx_pend;
  assign bit_cnt_o = cnt;

endmodule

// File: rtl/spi9_reg_engine.sv
module spi9_reg_engine
  import spi9_bridge_pkg::*;
#(
  parameter logic [7:0]  REG_FIRST = 8'hB0,
  parameter logic [7:0]  REG_LAST  = 8'hEB,
  parameter logic [15:0] DEV_ID    = 16'h5A31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_valid_i,
  input  frame_t      frm_i,
  output logic        push_o,
  output logic [7:0]  push_data_o,
  output logic [15:0] pay_left_o,
  output logic [15:0] cfg_word_o,
  output logic        tx_load_o,
  output logic [15:0] tx_word_o
);

  localparam int NREG = int'(REG_LAST) - int'(REG_FIRST) + 1;
  localparam int IW   = $clog2(NREG);

  function automatic logic in_win(input logic [7:0] a);
    return (a >= REG_FIRST) && (a <= REG_LAST);
  endfunction

  function automatic logic [IW-1:0] slot(input logic [7:0] a);
    return IW'(a - REG_FIRST);
  endfunction

  logic [15:0]   rf [NREG];
  logic          wr_stb, soft_rst;
  logic [IW-1:0] wr_slot;
  logic [15:0]   wr_data;

  // one storage word per slot; slot 0 is the fixed identifier
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (g == 0) begin : g_id
      assign rf[g] = DEV_ID;
    end else begin : g_rw
      logic [15:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= '0;
        else if (soft_rst)                         q <= '0;
        else if (wr_stb && wr_slot == IW'(g))      q <= wr_data;
      end
      assign rf[g] = q;
    end
  end

  logic [7:0]  cur_addr, target, lo_byte;
  logic        hi_phase, stream_on;
  arm_t        arm;
  logic [15:0] tgt_val, len_val;

  always_comb begin
    tgt_val = in_win(target) ? rf[slot(target)] : '0;
    len_val = in_win(ADR_PKT_LEN) ? rf[slot(ADR_PKT_LEN)] : '0;
  end

  assign cfg_word_o = in_win(ADR_CFG) ? rf[slot(ADR_CFG)] : '0;

  logic writable;
  assign writable = in_win(cur_addr) && (slot(cur_addr) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr    <= '0;
      target      <= '0;
      lo_byte     <= '0;
      hi_phase    <= 1'b0;
      stream_on   <= 1'b0;
      pay_left_o  <= '0;
      arm         <= ARM_IDLE;
      push_o      <= 1'b0;
      push_data_o <= '0;
      tx_load_o   <= 1'b0;
      tx_word_o   <= '0;
      wr_stb      <= 1'b0;
      wr_slot     <= '0;
      wr_data     <= '0;
      soft_rst    <= 1'b0;
    end else begin
      push_o    <= 1'b0;
      tx_load_o <= 1'b0;
      wr_stb    <= 1'b0;
      soft_rst  <= 1'b0;
      if (frm_valid_i && !frm_i.is_data) begin
        cur_addr <= frm_i.val;
        hi_phase <= 1'b0;
        if (frm_i.val == ADR_STREAM) begin
          stream_on  <= 1'b1;
          pay_left_o <= len_val;
        end else begin
          stream_on  <= 1'b0;
          pay_left_o <= '0;
        end
        case (arm)
          ARM_READY: begin
            if (frm_i.val != RD_KEY) begin
              target <= frm_i.val;
              arm    <= ARM_TARGET;
            end else begin
              arm <= ARM_IDLE;
            end
          end
          ARM_TARGET: begin
            if (frm_i.val == RD_KEY) begin
              tx_load_o <= 1'b1;
              tx_word_o <= tgt_val;
              arm       <= ARM_IDLE;
            end else begin
              arm <= (frm_i.val == ADR_RD_ARM) ? ARM_CMD : ARM_IDLE;
            end
          end
          default: arm <= (frm_i.val == ADR_RD_ARM) ? ARM_CMD : ARM_IDLE;
        endcase
      end else if (frm_valid_i) begin
        case (arm)
          ARM_CMD: arm <= (frm_i.val == RD_KEY)  ? ARM_KEY   : ARM_IDLE;
          ARM_KEY: arm <= (frm_i.val == RD_ZERO) ? ARM_READY : ARM_IDLE;
          default: arm <= ARM_IDLE;
        endcase
        if (stream_on) begin
          if (pay_left_o != '0) begin
            push_o      <= 1'b1;
            push_data_o <= frm_i.val;
            pay_left_o  <= pay_left_o - 16'd1;
          end
        end else if (writable) begin
          if (!hi_phase) begin
            lo_byte  <= frm_i.val;
            hi_phase <= 1'b1;
          end else begin
            hi_phase <= 1'b0;
            if (cur_addr == ADR_OPCTL && {frm_i.val, lo_byte} == SOFT_RST_WORD) begin
              soft_rst <= 1'b1;
            end else begin
              wr_stb  <= 1'b1;
              wr_slot <= slot(cur_addr);
              wr_data <= {frm_i.val, lo_byte};
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi9_byte_fifo.sv
module spi9_byte_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);

  localparam int             AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]  LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]    FULL = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign out_valid_o = (cnt != '0);
  assign out_data_o  = mem[rp];
  assign do_pop      = out_valid_o && out_ready_i;
  assign do_push     = push_i && (cnt != FULL);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/spi9_cfg_bridge.sv
module spi9_cfg_bridge
  import spi9_bridge_pkg::*;
#(
  parameter logic [7:0]  REG_FIRST  = 8'hB0,
  parameter logic [7:0]  REG_LAST   = 8'hEB,
  parameter logic [15:0] DEV_ID     = 16'h5A31,
  parameter int          FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_csn,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        pay_valid,
  input  logic        pay_ready,
  output logic [7:0]  pay_data,
  output logic [15:0] pay_left,
  output logic        cfg_hs_mode,
  output logic        cfg_video_en,
  output logic        cfg_dcs_pkt,
  output logic        cfg_ecc_en,
  output logic        cfg_eot_en
);

  frame_t            frm;
  logic              frm_valid, frm_is_data, tx_busy, tx_load, push;
  logic [FRM_CW-1:0] bit_cnt;
  logic [15:0]       tx_word, cfg_word;
  logic [7:0]        push_data;

  assign frm_is_data = frm.is_data;

  spi9_frame_link #(.WORD_BITS(16)) link_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_i      (spi_sck),
    .csn_i      (spi_csn),
    .mosi_i     (spi_mosi),
    .tx_load_i  (tx_load),
    .tx_word_i  (tx_word),
    .miso_o     (spi_miso),
    .tx_busy_o  (tx_busy),
    .frm_valid_o(frm_valid),
    .frm_o      (frm),
    .bit_cnt_o  (bit_cnt)
  );

  spi9_reg_engine #(
    .REG_FIRST(REG_FIRST),
    .REG_LAST (REG_LAST),
    .DEV_ID   (DEV_ID)
  ) eng_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid_i(frm_valid),
    .frm_i      (frm),
    .push_o     (push),
    .push_data_o(push_data),
    .pay_left_o (pay_left),
    .cfg_word_o (cfg_word),
    .tx_load_o  (tx_load),
    .tx_word_o  (tx_word)
  );

  spi9_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) fifo_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .push_data_i(push_data),
    .out_valid_o(pay_valid),
    .out_ready_i(pay_ready),
    .out_data_o (pay_data)
  );

  assign cfg_hs_mode  = cfg_word[CFG_HS_BIT];
  assign cfg_video_en = cfg_word[CFG_VID_BIT];
  assign cfg_dcs_pkt  = cfg_word[CFG_DCS_BIT];
  assign cfg_ecc_en   = cfg_word[CFG_ECC_BIT];
  assign cfg_eot_en   = cfg_word[CFG_EOT_BIT];

endmodule

// File: rtl/spi9_cfg_bridge_chk.sv
module spi9_cfg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_miso,
  input logic        pay_valid,
  input logic        pay_ready,
  input logic [7:0]  pay_data,
  input logic [15:0] pay_left,
  input logic [4:0]  cfg_bits,
  input logic        frm_valid,
  input logic        frm_is_data,
  input logic [3:0]  bit_cnt,
  input logic        tx_busy
);

  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> $past(bit_cnt) == 4'd8);

  assert_no_frame_in_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !frm_valid);

  assert_miso_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !spi_miso);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && !pay_ready) |=> (pay_valid && $stable(pay_data)));

  assert_left_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_left > $past(pay_left)) |-> $past(frm_valid && !frm_is_data));

  assert_left_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_left < $past(pay_left)) |->
      ((pay_left == $past(pay_left) - 16'd1) || $past(frm_valid && !frm_is_data)));

  assert_cfg_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_bits) |-> $past(frm_valid && frm_is_data, 2));

endmodule

bind spi9_cfg_bridge spi9_cfg_bridge_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_miso   (spi_miso),
  .pay_valid  (pay_valid),
  .pay_ready  (pay_ready),
  .pay_data   (pay_data),
  .pay_left   (pay_left),
  .cfg_bits   ({cfg_eot_en, cfg_ecc_en, cfg_dcs_pkt, cfg_video_en, cfg_hs_mode}),
  .frm_valid  (frm_valid),
  .frm_is_data(frm_is_data),
  .bit_cnt    (bit_cnt),
  .tx_busy    (tx_busy)
);

// File: tb/spi9_cfg_bridge_tb_top.sv
`timescale 1ns/1ps
module spi9_cfg_bridge_tb_top;

  localparam logic [15:0] ID = 16'h5A31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, pay_ready = 1'b1;
  logic miso, pay_valid, hs, vid, dcs, ecc, eot;
  logic [7:0]  pay_data;
  logic [15:0] pay_left;

  always #2.5 clk = ~clk;

  spi9_cfg_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .pay_data(pay_data), .pay_left(pay_left), .cfg_hs_mode(hs),
    .cfg_video_en(vid), .cfg_dcs_pkt(dcs), .cfg_ecc_en(ecc), .cfg_eot_en(eot)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] cap [64];
  int cap_n = 0;

  always @(posedge clk) begin
    if (rst_n && pay_valid && pay_ready && cap_n < 64) begin
      cap[cap_n] = pay_data;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    mosi = b;
    waitc(4);
    sck = 1'b1;
    waitc(4);
    sck = 1'b0;
  endtask

  task automatic frame(input logic is_data, input logic [7:0] v);
    csn = 1'b0;
    waitc(2);
    send_bit(is_data);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    waitc(4);
    csn = 1'b1;
    waitc(6);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] v);
    frame(1'b0, a);
    frame(1'b1, v[7:0]);
    frame(1'b1, v[15:8]);
  endtask

  task automatic shift16(output logic [15:0] v);
    csn = 1'b0;
    waitc(2);
    for (int i = 15; i >= 0; i--) begin
      mosi = 1'b0;
      waitc(4);
      v[i] = miso;
      sck = 1'b1;
      waitc(4);
      sck = 1'b0;
    end
    waitc(4);
    csn = 1'b1;
    waitc(6);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    frame(1'b0, 8'hD4);
    frame(1'b1, 8'hFA);
    frame(1'b1, 8'h00);
    frame(1'b0, a);
    frame(1'b0, 8'hFA);
    shift16(v);
  endtask

  function automatic logic [15:0] pat(input logic [7:0] a);
    return {a ^ 8'h3C, ~a};
  endfunction

  function automatic logic [4:0] cfgexp(input logic [15:0] v);
    return {v[9], v[8], v[6], v[3], v[0]};
  endfunction

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);

    // R11: reset state
    chk("R11 pay_valid", pay_valid, 0);
    chk("R11 pay_left", pay_left, 0);
    chk("R11 miso", miso, 0);
    chk("R11 cfg pins", {eot, ecc, dcs, vid, hs}, 0);
    rd(8'hB1, v);
    chk("R11 reg default", v, 0);

    // R3 / R8: identifier read-back
    rd(8'hB0, v);
    chk("R3 R8 id readback", v, ID);

    // R2 / R8: sweep of the whole window
    for (int a = 8'hB1; a <= 8'hEB; a++) begin
      if (a != 8'hBF) wr(8'(a), pat(8'(a)));
    end
    chk("R10 cfg after sweep", {eot, ecc, dcs, vid, hs}, cfgexp(pat(8'hB7)));
    for (int a = 8'hB0; a <= 8'hEB; a++) begin
      logic [15:0] e;
      if (a == 8'hB0)      e = ID;
      else if (a == 8'hBF) e = 16'h0000;
      else if (a == 8'hD4) e = 16'h00FA;
      else                 e = pat(8'(a));
      rd(8'(a), v);
      chk($sformatf("R2 R8 sweep addr %h", a), v, e);
    end

    // R3: writes outside the window or to the identifier
    wr(8'hEC, 16'h1234);
    wr(8'hAF, 16'h4321);
    wr(8'hB0, 16'hFFFF);
    rd(8'hB0, v);
    chk("R3 id unchanged", v, ID);
    rd(8'hB1, v);
    chk("R3 neighbour unchanged", v, pat(8'hB1));
    rd(8'hEC, v);
    chk("R3 out-of-window read zero", v, 0);

    // R4: command restarts low-byte phase
    frame(1'b0, 8'hB2);
    frame(1'b1, 8'h77);
    frame(1'b0, 8'hB2);
    frame(1'b1, 8'h34);
    frame(1'b1, 8'h12);
    rd(8'hB2, v);
    chk("R4 phase restart", v, 16'h1234);

    // R2: repeated pairs hit the same address
    frame(1'b0, 8'hB3);
    frame(1'b1, 8'h01);
    frame(1'b1, 8'h02);
    frame(1'b1, 8'h03);
    frame(1'b1, 8'h04);
    rd(8'hB3, v);
    chk("R2 repeated pair", v, 16'h0403);

    // R1: partial frame discarded on chip-select rise
    csn = 1'b0;
    waitc(2);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    waitc(4);
    csn = 1'b1;
    waitc(6);
    wr(8'hB5, 16'hABCD);
    rd(8'hB5, v);
    chk("R1 partial frame dropped", v, 16'hABCD);

    // R10: mode pins
    wr(8'hB7, 16'h0349);
    chk("R10 all pins set", {eot, ecc, dcs, vid, hs}, 5'b11111);
    wr(8'hB7, 16'hFCB6);
    chk("R10 all pins clear", {eot, ecc, dcs, vid, hs}, 5'b00000);
    wr(8'hB7, 16'h0208);
    chk("R10 mixed pins", {eot, ecc, dcs, vid, hs}, cfgexp(16'h0208));

    // R5: bounded payload stream
    pay_ready = 1'b1;
    cap_n = 0;
    wr(8'hBC, 16'd3);
    frame(1'b0, 8'hBF);
    chk("R5 budget loaded", pay_left, 3);
    for (int i = 0; i < 5; i++) frame(1'b1, 8'(8'hA1 + i));
    waitc(4);
    chk("R5 byte count", cap_n, 3);
    for (int i = 0; i < 3; i++) chk("R5 byte value", cap[i], 8'(8'hA1 + i));
    chk("R5 budget spent", pay_left, 0);

    // R6: command closes stream
    cap_n = 0;
    wr(8'hBC, 16'd5);
    frame(1'b0, 8'hBF);
    frame(1'b1, 8'h11);
    frame(1'b1, 8'h22);
    chk("R6 budget midway", pay_left, 3);
    frame(1'b0, 8'hB1);
    chk("R6 budget cleared", pay_left, 0);
    frame(1'b1, 8'h66);
    frame(1'b1, 8'h55);
    waitc(4);
    chk("R6 stream bytes", cap_n, 2);
    rd(8'hB1, v);
    chk("R6 data to new register", v, 16'h5566);

    // R7: back-pressure and overflow
    cap_n = 0;
    pay_ready = 1'b0;
    wr(8'hBC, 16'd6);
    frame(1'b0, 8'hBF);
    for (int i = 0; i < 6; i++) frame(1'b1, 8'(8'hC0 + i));
    chk("R7 valid held", pay_valid, 1);
    chk("R7 head byte", pay_data, 8'hC0);
    waitc(10);
    chk("R7 head stable", pay_data, 8'hC0);
    chk("R7 budget used", pay_left, 0);
    pay_ready = 1'b1;
    waitc(10);
    chk("R7 kept bytes", cap_n, 4);
    for (int i = 0; i < 4; i++) chk("R7 kept value", cap[i], 8'(8'hC0 + i));
    chk("R7 drained", pay_valid, 0);

    // R8: broken arming yields no read-back
    frame(1'b0, 8'hD4);
    frame(1'b1, 8'hFA);
    frame(1'b1, 8'h01);
    frame(1'b0, 8'hB5);
    frame(1'b0, 8'hFA);
    shift16(v);
    chk("R8 broken arm silent", v, 0);

    // R9: operation control
    wr(8'hB7, 16'h0349);
    wr(8'hC0, 16'h0101);
    rd(8'hC0, v);
    chk("R9 plain store", v, 16'h0101);
    chk("R9 cfg before", {eot, ecc, dcs, vid, hs}, 5'b11111);
    wr(8'hC0, 16'h0100);
    chk("R9 cfg after reset", {eot, ecc, dcs, vid, hs}, 5'b00000);
    rd(8'hB5, v);
    chk("R9 reg defaulted", v, 0);
    rd(8'hC0, v);
    chk("R9 opctl defaulted", v, 0);
    rd(8'hB0, v);
    chk("R9 id kept", v, ID);

    summary();
    $finish;
  end

endmodule